// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block drives the two gates of a half-bridge through a fixed cycle: low-side on, both off, high-side on, both off, then again. Each on-phase lasts a programmed number of clock cycles. Each both-off phase (the dead time) ends early when digitized comparator flags from the switch node show that the node is ready for the next switch. That happens when the node has reached the rail the next switch connects to, or when it has turned back at a local extremum inside a middle voltage band. If neither happens, the dead time ends after a programmed fallback count.

The six comparator flags arrive asynchronously and pass through a two-stage synchronizer. Two qualifier terms are formed from the synchronized flags, one for each side, and only a rising edge of a qualifier counts as an event. With adaptation disabled, every dead time takes the fallback length. The first dead time after reset always takes the fallback length, and the low side is always the first gate to turn on.

Top module: `hb_deadtime_seq`

## Requirements
- R1: `gate_hi` and `gate_lo` are never high in the same cycle, and every gate turn-on follows at least one cycle with both gates low.
- R2: While `rst` is high both gates are low. After `rst` falls, `gate_lo` turns on exactly `dead_cycles` cycles later, whatever the comparator flags do.
- R3: Turn-ons alternate: the low side first, and each high-side turn-on follows a low-side on-phase (and the reverse).
- R4: Each gate stays on for exactly `on_cycles` cycles.
- R5: A dead time with no accepted event lasts exactly `dead_cycles` cycles.
- R6: The high-side event is a rising edge of `rail_hi_in | (above_low_in & below_dly_in)`. If the qualifier rises in the cycle that starts d cycles into the dead time that precedes the high side, that dead time lasts min(d+3, `dead_cycles`) cycles.
- R7: The low-side event is a rising edge of `rail_lo_in | (below_high_in & above_dly_in)`. It shortens the dead time that precedes the low side with the same min(d+3, `dead_cycles`) timing.
- R8: An extremum flag (`below_dly_in` for the high side, `above_dly_in` for the low side) is ignored unless its band flag (`above_low_in` or `below_high_in`, respectively) is also high.
- R9: During a dead time only the next switch's qualifier is examined. Flags that qualify only the switch that just turned off leave the dead time at `dead_cycles`.
- R10: A qualifier that is already high when the dead time begins produces no event, and the dead time lasts `dead_cycles`.
- R11: With `adapt_en` low, every dead time lasts `dead_cycles` whatever the flags do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adapt_en | input | 1 | Enables event-terminated dead times |
| on_cycles | input | 8 | On-phase length in cycles |
| dead_cycles | input | 8 | Fallback dead-time length in cycles |
| rail_hi_in | input | 1 | Node has reached the positive rail (asynchronous) |
| rail_lo_in | input | 1 | Node has reached ground (asynchronous) |
| above_low_in | input | 1 | Node is above the lower band edge (about 10% of supply) |
| below_high_in | input | 1 | Node is below the upper band edge (about 90% of supply) |
| below_dly_in | input | 1 | Node is below its delayed copy (falling) |
| above_dly_in | input | 1 | Node is above its delayed copy (rising) |
| gate_hi | output | 1 | High-side gate command, registered |
| gate_lo | output | 1 | Low-side gate command, registered |

## Verification
The checker assumes that `on_cycles` and `dead_cycles` change only while `rst` is high, and that both are at least one. Its on-time and dead-time bounds compare run lengths against these port values. The bench writes both settings only during reset, uses values of three or more, and keeps `on_cycles` at four or more. That margin clears a flag pattern through the synchronizer before the next dead time begins, so each measurement starts from quiet flags.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    localparam int CNT_W       = 8;
    localparam int SYNC_STAGES = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic rail_hi;
        logic rail_lo;
        logic above_low;
        logic below_high;
        logic below_dly;
        logic above_dly;
    } node_flags_t;

    localparam int FLAG_W = $bits(node_flags_t);

    typedef enum logic [1:0] {
        PH_DEAD_LO = 2'd0,
        PH_LO_ON   = 2'd1,
        PH_DEAD_HI = 2'd2,
        PH_HI_ON   = 2'd3
    } phase_t;

    // a programmed length of zero behaves as one cycle
    function automatic logic [CNT_W:0] min_one(input cnt_t v);
        return (v == '0) ? (CNT_W+1)'(1) : {1'b0, v};
    endfunction

    function automatic logic hi_ready(input node_flags_t f);
        return f.rail_hi | (f.above_low & f.below_dly);
    endfunction

    function automatic logic lo_ready(input node_flags_t f);
        return f.rail_lo | (f.below_high & f.above_dly);
    endfunction

endpackage

// File: rtl/hbdt_sync.sv
module hbdt_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbdt_event.sv
module hbdt_event
    import hbdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  node_flags_t flags_s,
    output logic        hi_edge,
    output logic        lo_edge
);
    logic hi_now, lo_now, hi_prev, lo_prev;

    assign hi_now = hi_ready(flags_s);
    assign lo_now = lo_ready(flags_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_prev <= 1'b0;
            lo_prev <= 1'b0;
        end else begin
            hi_prev <= hi_now;
            lo_prev <= lo_now;
        end
    end

    assign hi_edge = hi_now & ~hi_prev;
    assign lo_edge = lo_now & ~lo_prev;
endmodule

// File: rtl/hbdt_timer.sv
module hbdt_timer
    import hbdt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  cnt_t limit,
    output logic done
);
    cnt_t cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) cnt <= '0;
        else if (cnt != '1) cnt <= cnt + 1'b1;
    end

    // done on the last cycle of a phase of min_one(limit) cycles
    assign done = ({1'b0, cnt} + (CNT_W+1)'(1)) >= min_one(limit);
endmodule

// File: rtl/hb_deadtime_seq.sv
module hb_deadtime_seq
    import hbdt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adapt_en,
    input  logic [CNT_W-1:0]     on_cycles,
    input  logic [CNT_W-1:0]     dead_cycles,
    input  logic                 rail_hi_in,
    input  logic                 rail_lo_in,
    input  logic                 above_low_in,
    input  logic                 below_high_in,
    input  logic                 below_dly_in,
    input  logic                 above_dly_in,
    output logic                 gate_hi,
    output logic                 gate_lo
);
    node_flags_t raw_flags, sync_flags;
    logic        hi_edge, lo_edge;
    logic        phase_done, advance, boot;
    cnt_t        limit;
    phase_t      phase, phase_nx;

    assign raw_flags = '{rail_hi:    rail_hi_in,
                         rail_lo:    rail_lo_in,
                         above_low:  above_low_in,
                         below_high: below_high_in,
                         below_dly:  below_dly_in,
                         above_dly:  above_dly_in};

    hbdt_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_flags),
        .q   (sync_flags)
    );

    hbdt_event i_event (
        .clk     (clk),
        .rst     (rst),
        .flags_s (sync_flags),
        .hi_edge (hi_edge),
        .lo_edge (lo_edge)
    );

    assign limit = (phase == PH_LO_ON || phase == PH_HI_ON) ? on_cycles : dead_cycles;

    hbdt_timer i_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (advance),
        .limit (limit),
        .done  (phase_done)
    );

    // only the next switch's event can end a dead time
    always_comb begin
        unique case (phase)
            PH_DEAD_LO: advance = phase_done | (adapt_en & ~boot & lo_edge);
            PH_DEAD_HI: advance = phase_done | (adapt_en & hi_edge);
            default:    advance = phase_done;
        endcase
        phase_nx = phase_t'(phase + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_DEAD_LO;
            boot    <= 1'b1;
            gate_hi <= 1'b0;
            gate_lo <= 1'b0;
        end else if (advance) begin
            phase   <= phase_nx;
            gate_lo <= (phase_nx == PH_LO_ON);
            gate_hi <= (phase_nx == PH_HI_ON);
            if (phase == PH_DEAD_LO) boot <= 1'b0;
        end
    end
endmodule

// File: rtl/hbdt_checker.sv
module hbdt_checker
    import hbdt_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic gate_hi,
    input logic gate_lo,
    input cnt_t on_cycles,
    input cnt_t dead_cycles
);
    logic [CNT_W:0] hi_run, lo_run, off_run;
    logic           last_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_run  <= '0;
            lo_run  <= '0;
            off_run <= '0;
            last_lo <= 1'b0;
        end else begin
            hi_run  <= gate_hi ? hi_run + 1'b1 : '0;
            lo_run  <= gate_lo ? lo_run + 1'b1 : '0;
            off_run <= (!gate_hi && !gate_lo) ? off_run + 1'b1 : '0;
            if (gate_lo) last_lo <= 1'b1;
            else if (gate_hi) last_lo <= 1'b0;
        end
    end

    p_gates_exclusive_r1: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));

    p_gap_before_hi_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> !$past(gate_lo));

    p_gap_before_lo_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> !$past(gate_hi));

    p_hi_after_lo_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> last_lo);

    p_lo_after_hi_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> !last_lo);

    p_hi_on_time_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_hi) |-> hi_run == min_one(on_cycles));

    p_lo_on_time_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_lo) |-> lo_run == min_one(on_cycles));

    p_dead_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        (!gate_hi && !gate_lo) |-> off_run < min_one(dead_cycles));
endmodule

bind hb_deadtime_seq hbdt_checker i_hbdt_checker (
    .clk         (clk),
    .rst         (rst),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .on_cycles   (on_cycles),
    .dead_cycles (dead_cycles)
);

// File: tb/test_hb_deadtime_seq.sv
module test_hb_deadtime_seq;
    import hbdt_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adapt_en = 1'b1;
    cnt_t        on_cycles = 8'd4;
    cnt_t        dead_cycles = 8'd4;
    node_flags_t stim = '0;
    logic        gate_hi, gate_lo;

    int checks = 0;
    int errors = 0;
    logic prev_hi = 1'b0, prev_lo = 1'b0;
    logic last_was_lo = 1'b0;

    always #2 clk = ~clk;

    hb_deadtime_seq i_hb_deadtime_seq (
        .clk           (clk),
        .rst           (rst),
        .adapt_en      (adapt_en),
        .on_cycles     (on_cycles),
        .dead_cycles   (dead_cycles),
        .rail_hi_in    (stim.rail_hi),
        .rail_lo_in    (stim.rail_lo),
        .above_low_in  (stim.above_low),
        .below_high_in (stim.below_high),
        .below_dly_in  (stim.below_dly),
        .above_dly_in  (stim.above_dly),
        .gate_hi       (gate_hi),
        .gate_lo       (gate_lo)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // R1 and R3 monitored on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            check(!(gate_hi && gate_lo), "R1 exclusive", int'({gate_hi, gate_lo}), 0);
            if (gate_hi && !prev_hi) begin
                check(!prev_lo, "R1 gap hi", int'(prev_lo), 0);
                check(last_was_lo, "R3 hi follows lo", int'(last_was_lo), 1);
            end
            if (gate_lo && !prev_lo) begin
                check(!prev_hi, "R1 gap lo", int'(prev_hi), 0);
                check(!last_was_lo, "R3 lo follows hi", int'(last_was_lo), 0);
            end
            if (gate_lo) last_was_lo = 1'b1;
            else if (gate_hi) last_was_lo = 1'b0;
        end else begin
            last_was_lo = 1'b0;
        end
        prev_hi = gate_hi;
        prev_lo = gate_lo;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    // measure the dead time ahead of one side; pattern applied d cycles in,
    // or during the preceding on-phase when early is set
    task automatic measure(input bit side_hi, input node_flags_t pat, input int d,
                           input bit early, output int got);
        int guard = 0;
        while (!(side_hi ? gate_lo : gate_hi) && guard < 400) begin
            @(negedge clk); guard++;
        end
        if (early) stim = pat;
        while ((side_hi ? gate_lo : gate_hi) && guard < 800) begin
            @(negedge clk); guard++;
        end
        got = 0;
        while (!(side_hi ? gate_hi : gate_lo) && got < 400) begin
            if (!early && got == d) stim = pat;
            @(negedge clk);
            got++;
        end
        stim = '0;
    endtask

    task automatic start_cfg(input int dead, input int on, input bit en);
        int k;
        int len;
        rst = 1'b1;
        stim = '0;
        dead_cycles = cnt_t'(dead);
        on_cycles = cnt_t'(on);
        adapt_en = en;
        repeat (3) @(negedge clk);
        check(!gate_hi && !gate_lo, "R2 reset state", int'({gate_hi, gate_lo}), 0);
        // low-side qualifier rises during the boot dead time: must not shorten it
        stim.rail_lo = 1'b1;
        stim.below_high = 1'b1;
        stim.above_dly = 1'b1;
        rst = 1'b0;
        k = 0;
        while (!gate_lo && k < 400) begin
            check(!gate_hi, "R2 low side first", int'(gate_hi), 0);
            @(negedge clk); k++;
        end
        check(k == dead, "R2 boot dead time", k, dead);
        stim = '0;
        len = 0;
        while (gate_lo && len < 400) begin
            @(negedge clk); len++;
        end
        check(len == on, "R4 low on-time", len, on);
        k = 0;
        while (!gate_hi && k < 400) begin
            @(negedge clk); k++;
        end
        len = 0;
        while (gate_hi && len < 400) begin
            @(negedge clk); len++;
        end
        check(len == on, "R4 high on-time", len, on);
    endtask

    task automatic sweep(input int dead, input bit en, input int dmax);
        int got, exp;
        string tag;
        node_flags_t pat;
        bit q, q_other, ext_out;
        for (int side = 0; side < 2; side++) begin
            for (int p = 0; p < 64; p++) begin
                for (int d = 0; d <= dmax; d++) begin
                    pat = node_flags_t'(p);
                    q = side ? (pat.rail_hi | (pat.above_low & pat.below_dly))
                             : (pat.rail_lo | (pat.below_high & pat.above_dly));
                    q_other = side ? (pat.rail_lo | (pat.below_high & pat.above_dly))
                                   : (pat.rail_hi | (pat.above_low & pat.below_dly));
                    ext_out = side ? (pat.below_dly & !pat.above_low)
                                   : (pat.above_dly & !pat.below_high);
                    exp = (en && q) ? ((d + 3 < dead) ? d + 3 : dead) : dead;
                    if (!en) tag = "R11 disabled";
                    else if (q) tag = side ? "R6 high event" : "R7 low event";
                    else if (ext_out) tag = "R8 out of band";
                    else if (q_other) tag = "R9 opposite side";
                    else tag = "R5 fallback";
                    measure(bit'(side), pat, d, 1'b0, got);
                    check(got == exp, tag, got, exp);
                end
            end
        end
    endtask

    task automatic level_cases(input int dead);
        int got;
        node_flags_t pat;
        // R10: qualifier already high when the dead time opens
        pat = '0; pat.rail_hi = 1'b1;
        measure(1'b1, pat, 0, 1'b1, got);
        check(got == dead, "R10 level rail high", got, dead);
        pat = '0; pat.above_low = 1'b1; pat.below_dly = 1'b1;
        measure(1'b1, pat, 0, 1'b1, got);
        check(got == dead, "R10 level local max", got, dead);
        pat = '0; pat.rail_lo = 1'b1;
        measure(1'b0, pat, 0, 1'b1, got);
        check(got == dead, "R10 level rail low", got, dead);
        pat = '0; pat.below_high = 1'b1; pat.above_dly = 1'b1;
        measure(1'b0, pat, 0, 1'b1, got);
        check(got == dead, "R10 level local min", got, dead);
    endtask

    initial begin
        start_cfg(4, 4, 1'b1);
        sweep(4, 1'b1, 4);
        level_cases(4);

        start_cfg(7, 5, 1'b1);
        sweep(7, 1'b1, 7);
        level_cases(7);

        start_cfg(5, 4, 1'b0);
        sweep(5, 1'b0, 0);

        finish_run();
    end
endmodule